// File: doc/BRIEF.md
# Debounced Fault Escalation Monitor

This block watches a single asynchronous fault line coming out of a signal-processing pipeline. It decides whether that line shows a real, persistent fault and, if it does, asks for recovery and records the event. The line passes through a two-flop synchronizer. It is then sampled at most once per fixed interval of a free-running millisecond tick that the block receives as an input.

A report needs a run of consecutive asserted samples. Each report raises a one-cycle recovery request and bumps a saturating error counter. Once that counter goes past a limit, an emergency latch sets and holds until software-independent logic pulses the clear input. The recovery action itself is left to whatever consumes the request pulse.

The timestamp of a sample is taken at the moment the interval expires, before the fault is looked at. A line that stays asserted therefore still waits a full interval between samples, and after each report it must build a fresh streak.

Top module: `fault_escalation_monitor`

## Requirements
- R1: After reset, recovery_pulse, error_count and emergency are all 0. The first sample is taken when tick_ms has advanced by INTERVAL_MS (default 1000) from its value on the first clock after reset. Later samples follow each INTERVAL_MS after the previous one.
- R2: A single asserted sample never produces a report. A report is issued when STREAK_NEED (default 2) consecutive samples are asserted.
- R3: The sample timestamp is recorded when the interval expires, whatever the fault value. While the fault stays asserted, no further sample and no further report occur until tick_ms has advanced another full INTERVAL_MS.
- R4: After a report the streak restarts from zero. The next asserted sample alone does not report; the one after it does.
- R5: A sample that finds the fault deasserted clears the streak.
- R6: emergency sets on the report that takes error_count above ERR_LIMIT (default 10). It stays set until latch_clear is high for a clock. After a clear, it sets again on the next report while the count is above the limit.
- R7: Elapsed time is tick_ms minus the stored timestamp, computed modulo 2^32, so sampling stays correct across a counter wrap.
- R8: Each report raises recovery_pulse for exactly one clock. error_count rises by one on the following clock and saturates at 2^CNT_W-1. The pulse still fires at saturation.
- R9: fault_async passes through two synchronizer flops. A change applied in the same cycle as a sample is not seen by that sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_ms | input | 32 | Free-running millisecond counter |
| fault_async | input | 1 | Asynchronous fault line, high = fault |
| latch_clear | input | 1 | Clears the emergency latch |
| recovery_pulse | output | 1 | One-cycle recovery request per report |
| error_count | output | CNT_W | Saturating count of reports |
| emergency | output | 1 | Sticky emergency latch |

## Verification
The bench builds the block with CNT_W set to 4 and keeps the default interval, streak length and limit. At that width the counter saturates at 15, only a few reports past the emergency threshold, so both the escalation and the saturation ceiling are reached in a short run. The tick is driven directly rather than counted, which lets the bench land samples exactly on interval boundaries and one tick short of them. It also lets the bench jump the tick next to the 32-bit wrap to exercise the modulo elapsed-time arithmetic.

// File: rtl/fem_pkg.sv
package fem_pkg;
  localparam int TICK_W = 32;

  // Modulo-2^32 distance from a stored stamp to the current tick
  function automatic logic [TICK_W-1:0] elapsed_ms(input logic [TICK_W-1:0] now,
                                                   input logic [TICK_W-1:0] stamp);
    return now - stamp;
  endfunction

  function automatic logic interval_due(input logic [TICK_W-1:0] now,
                                        input logic [TICK_W-1:0] stamp,
                                        input logic [TICK_W-1:0] interval);
    return elapsed_ms(now, stamp) >= interval;
  endfunction
endpackage

// File: rtl/fem_sync.sv
module fem_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d_async};
  end

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/fem_sampler.sv
module fem_sampler
  import fem_pkg::*;
#(
  parameter int INTERVAL_MS = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TICK_W-1:0] tick_ms,
  output logic              sample_strobe,
  output logic [TICK_W-1:0] last_stamp
);
  localparam logic [TICK_W-1:0] INTERVAL = TICK_W'(INTERVAL_MS);

  logic armed;

  assign sample_strobe = armed && interval_due(tick_ms, last_stamp, INTERVAL);

  // Stamp is taken as soon as the interval expires, independent of the fault
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed      <= 1'b0;
      last_stamp <= '0;
    end else if (!armed) begin
      armed      <= 1'b1;
      last_stamp <= tick_ms;
    end else if (sample_strobe) begin
      last_stamp <= tick_ms;
    end
  end
endmodule

// File: rtl/fem_debounce.sv
module fem_debounce #(
  parameter int STREAK_NEED = 2,
  localparam int SW = $clog2(STREAK_NEED + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sample_strobe,
  input  logic          fault_sync,
  output logic          report,
  output logic [SW-1:0] streak
);
  localparam logic [SW-1:0] LAST = SW'(STREAK_NEED - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      streak <= '0;
      report <= 1'b0;
    end else begin
      report <= 1'b0;
      if (sample_strobe) begin
        if (!fault_sync) begin
          streak <= '0;
        end else if (streak == LAST) begin
          streak <= '0;
          report <= 1'b1;
        end else begin
          streak <= streak + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/fem_escalate.sv
module fem_escalate #(
  parameter int CNT_W     = 8,
  parameter int ERR_LIMIT = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             report,
  input  logic             latch_clear,
  output logic [CNT_W-1:0] count,
  output logic             latch
);
  localparam logic [CNT_W-1:0] CMAX  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(ERR_LIMIT);

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == CMAX) ? v : v + 1'b1;
  endfunction

  logic [CNT_W-1:0] count_nx;
  assign count_nx = sat_inc(count);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      latch <= 1'b0;
    end else begin
      if (report) count <= count_nx;
      if (report && count_nx > LIMIT) latch <= 1'b1;
      else if (latch_clear)           latch <= 1'b0;
    end
  end
endmodule

// File: rtl/fault_escalation_monitor.sv
module fault_escalation_monitor
  import fem_pkg::*;
#(
  parameter int INTERVAL_MS = 1000,
  parameter int STREAK_NEED = 2,
  parameter int CNT_W       = 8,
  parameter int ERR_LIMIT   = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TICK_W-1:0] tick_ms,
  input  logic              fault_async,
  input  logic              latch_clear,
  output logic              recovery_pulse,
  output logic [CNT_W-1:0]  error_count,
  output logic              emergency
);
  localparam int SW = $clog2(STREAK_NEED + 1);

  // Internal events brought out as named wires
  logic              fault_sync;
  logic              sample_strobe;
  logic [TICK_W-1:0] last_stamp;
  logic [SW-1:0]     streak;
  logic              report;

  fem_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(fault_async), .q_sync(fault_sync)
  );

  fem_sampler #(.INTERVAL_MS(INTERVAL_MS)) u_samp (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms),
    .sample_strobe(sample_strobe), .last_stamp(last_stamp)
  );

  fem_debounce #(.STREAK_NEED(STREAK_NEED)) u_deb (
    .clk(clk), .rst_n(rst_n), .sample_strobe(sample_strobe),
    .fault_sync(fault_sync), .report(report), .streak(streak)
  );

  fem_escalate #(.CNT_W(CNT_W), .ERR_LIMIT(ERR_LIMIT)) u_esc (
    .clk(clk), .rst_n(rst_n), .report(report), .latch_clear(latch_clear),
    .count(error_count), .latch(emergency)
  );

  assign recovery_pulse = report;
endmodule

// File: rtl/fem_checker.sv
module fem_checker #(
  parameter int CNT_W = 8,
  parameter int SW    = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [31:0]      tick_ms,
  input logic             fault_sync,
  input logic             sample_strobe,
  input logic [31:0]      last_stamp,
  input logic [SW-1:0]    streak,
  input logic             recovery_pulse,
  input logic [CNT_W-1:0] error_count,
  input logic             emergency,
  input logic             latch_clear
);
  // R2
  report_needs_high_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    recovery_pulse |-> $past(sample_strobe && fault_sync));

  // R3
  stamp_taken_on_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_strobe |=> last_stamp == $past(tick_ms));

  // R4
  streak_rearmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    recovery_pulse |-> streak == '0);

  // R8
  single_cycle_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    recovery_pulse |=> !recovery_pulse);

  // R8
  count_moves_on_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !recovery_pulse |=> $stable(error_count));

  // R6
  latch_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (emergency && !latch_clear) |=> emergency);
endmodule

bind fault_escalation_monitor fem_checker #(.CNT_W(CNT_W), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .fault_sync(fault_sync),
  .sample_strobe(sample_strobe), .last_stamp(last_stamp), .streak(streak),
  .recovery_pulse(recovery_pulse), .error_count(error_count),
  .emergency(emergency), .latch_clear(latch_clear)
);

// File: tb/sim_fault_escalation_monitor.sv
module sim_fault_escalation_monitor;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [31:0]   tick_ms = '0;
  logic          fault_async = 1'b0;
  logic          latch_clear = 1'b0;
  logic          recovery_pulse;
  logic [CW-1:0] error_count;
  logic          emergency;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] tnow;
  int exp_cnt;
  logic done = 1'b0;

  always #5 clk = ~clk;

  fault_escalation_monitor #(.CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .fault_async(fault_async),
    .latch_clear(latch_clear), .recovery_pulse(recovery_pulse),
    .error_count(error_count), .emergency(emergency)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_fault(input logic v);
    fault_async = v;
    repeat (3) @(posedge clk);
    #1;
  endtask

  // Drive a tick value; report whether a pulse appeared and check it lasted one clock
  task automatic sample_at(input logic [31:0] t, output logic pl);
    tick_ms = t;
    @(posedge clk); #1;
    pl = recovery_pulse;
    @(posedge clk); #1;
    check("R8 pulse width", int'(recovery_pulse), 0);
  endtask

  // Two asserted samples one interval apart; streak must be zero on entry
  task automatic report_pair(input string req);
    logic pl;
    sample_at(tnow, pl);
    check({req, " first sample silent"}, int'(pl), 0);
    tnow += 1000;
    sample_at(tnow, pl);
    check({req, " second sample reports"}, int'(pl), 1);
    exp_cnt = (exp_cnt == 15) ? 15 : exp_cnt + 1;
    check({req, " count"}, int'(error_count), exp_cnt);
    tnow += 1000;
  endtask

  task automatic t_reset;
    check("R1 pulse at reset", int'(recovery_pulse), 0);
    check("R1 count at reset", int'(error_count), 0);
    check("R1 emergency at reset", int'(emergency), 0);
  endtask

  task automatic t_glitch_and_sync;
    logic pl;
    // R9: fault raised in the sampling cycle itself is not seen
    tick_ms = 32'd999;
    @(posedge clk); #1;
    check("R1 no sample before interval", int'(recovery_pulse), 0);
    fault_async = 1'b1;
    sample_at(32'd1000, pl);
    check("R9 sync hides same-cycle change", int'(pl), 0);
    repeat (2) @(posedge clk); #1;
    sample_at(32'd2000, pl);
    check("R2 single asserted sample silent", int'(pl), 0);
    set_fault(1'b0);
    sample_at(32'd3000, pl);
    check("R5 low sample silent", int'(pl), 0);
    set_fault(1'b1);
    sample_at(32'd4000, pl);
    check("R5 streak restarted after low sample", int'(pl), 0);
  endtask

  task automatic t_rate_limit;
    logic pl;
    sample_at(32'd4500, pl);
    check("R3 no sample mid interval", int'(pl), 0);
    sample_at(32'd4999, pl);
    check("R3 no sample one tick early", int'(pl), 0);
    sample_at(32'd5000, pl);
    check("R2 second asserted sample reports", int'(pl), 1);
    exp_cnt = 1;
    check("R8 count after report", int'(error_count), 1);
    // hold tick with fault held: no further sampling
    repeat (20) @(posedge clk); #1;
    check("R3 held fault no extra report", int'(error_count), 1);
    sample_at(32'd5999, pl);
    check("R3 still waiting full interval", int'(pl), 0);
  endtask

  task automatic t_rearm;
    logic pl;
    sample_at(32'd6000, pl);
    check("R4 one new sample after report silent", int'(pl), 0);
    sample_at(32'd7000, pl);
    check("R4 second new sample reports", int'(pl), 1);
    exp_cnt = 2;
    check("R4 count", int'(error_count), 2);
  endtask

  task automatic t_wrap;
    logic pl;
    sample_at(32'hFFFF_FF00, pl);
    check("R7 sample before wrap silent", int'(pl), 0);
    sample_at(32'h0000_02E7, pl);
    check("R7 one tick short across wrap", int'(pl), 0);
    sample_at(32'h0000_02E8, pl);
    check("R7 full interval across wrap reports", int'(pl), 1);
    exp_cnt = 3;
    check("R7 count", int'(error_count), 3);
    tnow = 32'h0000_02E8 + 1000;
  endtask

  task automatic t_escalate;
    for (int i = 0; i < 7; i++) begin
      report_pair("R6 build up");
      check("R6 no emergency at or below limit", int'(emergency), 0);
    end
    report_pair("R6 crossing");
    check("R6 emergency above limit", int'(emergency), 1);
    set_fault(1'b0);
    repeat (30) @(posedge clk); #1;
    check("R6 latch holds", int'(emergency), 1);
    latch_clear = 1'b1;
    @(posedge clk); #1;
    latch_clear = 1'b0;
    check("R6 latch cleared", int'(emergency), 0);
    repeat (5) @(posedge clk); #1;
    check("R6 stays clear without report", int'(emergency), 0);
    check("R6 count kept by clear", int'(error_count), 11);
    set_fault(1'b1);
    report_pair("R6 re-set");
    check("R6 re-set on next report", int'(emergency), 1);
  endtask

  task automatic t_saturate;
    for (int i = 0; i < 3; i++) report_pair("R8 climb");
    check("R8 at max", int'(error_count), 15);
    report_pair("R8 saturated");
    check("R8 holds at max", int'(error_count), 15);
  endtask

  initial begin
    exp_cnt = 0;
    repeat (3) @(posedge clk);
    #1;
    t_reset;
    rst_n = 1'b1;
    @(posedge clk); #1;          // baseline stamp = 0
    t_glitch_and_sync;
    t_rate_limit;
    t_rearm;
    t_wrap;
    t_escalate;
    t_saturate;
    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule